// File: doc/BRIEF.md
# Dual-Rate System Clock Divider

This block derives the general system clock timing from a fast reference clock. It counts reference cycles and marks out output periods whose length is a power of two. The length comes from one of two programmed division fields. The fast field covers divide by 1 to 64. The slow field covers divide by 2 to 64 and also divide by 256. Software writes both fields and two control bits through a single-cycle write strobe. One bit selects the slow rate. The other lets a companion controller's busy line pull the clock back to the fast rate for as long as that controller is working.

The block has two timing outputs. The first is a one-cycle enable tick in the last reference cycle of each output period. The second is a 50% duty phase level, high in the first half of each period. At divide by 1 both outputs stay high. A new divisor, or a new rate choice, is picked up only at a period boundary, so a period is never cut short. A status output shows which of the two rates is currently applied. Busy and all write inputs are synchronous to the reference clock.

Top module: `sysclk_rate_divider`

## Requirements
- R1: After a synchronous reset, the fast field decodes to divide by 1, the slow field code is 000, both control bits are 0, and the block runs at divide by 1. In this state gclk_tick=1, gclk_phase=1 and rate_is_low=0.
- R2: Fast-field code k (0 to 6) selects a period of 2^k reference cycles. Code 111 is reserved.
- R3: Slow-field code k (0 to 5) selects a period of 2^(k+1) reference cycles. Code 111 selects 256 cycles. Code 110 is reserved.
- R4: With cfg_sel_low=0 the fast divisor is used. With cfg_sel_low=1 the slow divisor is used, except as stated in R5.
- R5: With cfg_sel_low=1 and cfg_wake_en=1, the fast divisor is used while ctl_busy=1, and the slow divisor again once ctl_busy=0.
- R6: With cfg_wake_en=0, ctl_busy has no effect on the applied rate.
- R7: A new field value, rate choice or busy level is sampled only in the last cycle of an output period (gclk_tick=1). It governs the periods that follow, from the next cycle on. A period in progress keeps its length.
- R8: Writing a reserved code to a field leaves that field at its last valid value. The other fields in the same write are still updated.
- R9: gclk_tick is high exactly in the last reference cycle of each output period. At divide by 1 it is high in every cycle.
- R10: gclk_phase is high for the first half of each period and low for the second half. At divide by 1 it is always high.
- R11: rate_is_low is 1 while the slow divisor is applied and 0 while the fast divisor is applied. It changes only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for all configuration fields |
| cfg_hi_code | input | 3 | Fast-rate division code |
| cfg_lo_code | input | 3 | Slow-rate division code |
| cfg_sel_low | input | 1 | 1 selects the slow rate |
| cfg_wake_en | input | 1 | 1 lets controller busy force the fast rate |
| ctl_busy | input | 1 | Companion controller busy (1) or idle (0) |
| gclk_tick | output | 1 | Enable pulse in the last cycle of each output period |
| gclk_phase | output | 1 | 50% duty divided clock level |
| rate_is_low | output | 1 | Applied rate: 1 slow, 0 fast |

## Verification
The fields can be written, or busy can change, in the same cycle as a period boundary. In that cycle the applied divisor loads from the values that held before the edge, and the write itself lands in the configuration registers. Random writes and busy toggles run at high density over periods as short as one cycle, so these collisions happen often. A bench model tracks each case: it takes the boundary decision from the pre-edge configuration and only then applies the write, and the bench compares tick, phase and rate status against it in every cycle. Directed cases also write a new divisor in the middle of a long period and confirm that the old period still ends on time.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

    localparam int CODE_W  = 3;
    localparam int SHIFT_W = 4;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    typedef enum logic {
        RATE_HIGH = 1'b0,
        RATE_LOW  = 1'b1
    } rate_e;

    // result of decoding one field code
    typedef struct packed {
        logic   ok;
        shift_t sh;
    } dec_t;

    // stored configuration, divisors held as log2 values
    typedef struct packed {
        shift_t hi_sh;
        shift_t lo_sh;
        logic   sel_low;
        logic   wake_en;
    } cfg_t;

    // rate choice handed to the period generator
    typedef struct packed {
        rate_e  rate;
        shift_t sh;
    } pick_t;

    localparam code_t HI_RESERVED = 3'b111;
    localparam code_t LO_RESERVED = 3'b110;
    localparam code_t LO_MAX_CODE = 3'b111;
    localparam shift_t LO_MAX_SH  = 4'd8;

    // fast field: code is log2 of the divisor
    function automatic dec_t decode_hi(code_t c);
        dec_t d;
        d.ok = (c != HI_RESERVED);
        d.sh = shift_t'(c);
        return d;
    endfunction

    // slow field: divisor starts at 2, top code jumps to 256
    function automatic dec_t decode_lo(code_t c);
        dec_t d;
        d.ok = (c != LO_RESERVED);
        if (c == LO_MAX_CODE) d.sh = LO_MAX_SH;
        else                  d.sh = shift_t'(c) + shift_t'(1);
        return d;
    endfunction

    localparam cfg_t CFG_RESET = '{hi_sh: '0, lo_sh: shift_t'(1),
                                   sel_low: 1'b0, wake_en: 1'b0};

endpackage

// File: rtl/sdiv_cfg_regs.sv
module sdiv_cfg_regs
    import sysclk_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  code_t hi_code,
    input  code_t lo_code,
    input  logic  sel_low,
    input  logic  wake_en,
    output cfg_t  cfg
);

    dec_t hi_dec;
    dec_t lo_dec;
    cfg_t cfg_q;

    always_comb begin
        hi_dec = decode_hi(hi_code);
        lo_dec = decode_lo(lo_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr) begin
            // a reserved code keeps the field as it was
            if (hi_dec.ok) cfg_q.hi_sh <= hi_dec.sh;
            if (lo_dec.ok) cfg_q.lo_sh <= lo_dec.sh;
            cfg_q.sel_low <= sel_low;
            cfg_q.wake_en <= wake_en;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/sdiv_rate_sel.sv
module sdiv_rate_sel
    import sysclk_div_pkg::*;
(
    input  cfg_t  cfg,
    input  logic  busy,
    output pick_t pick
);

    logic go_low;

    always_comb begin
        go_low = cfg.sel_low && !(cfg.wake_en && busy);
        if (go_low) begin
            pick.rate = RATE_LOW;
            pick.sh   = cfg.lo_sh;
        end else begin
            pick.rate = RATE_HIGH;
            pick.sh   = cfg.hi_sh;
        end
    end

endmodule

// File: rtl/sdiv_period_gen.sv
module sdiv_period_gen
    import sysclk_div_pkg::*;
#(
    parameter int MAX_SHIFT = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  pick_t  pick,
    output logic   tick,
    output logic   phase,
    output rate_e  rate,
    output shift_t sh
);

    localparam int CNT_W  = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    pick_t             app_q;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] half;
    logic [SPAN_W-1:0] last;

    always_comb begin
        span  = SPAN_W'(1) << app_q.sh;
        half  = span >> 1;
        last  = span - SPAN_W'(1);
        tick  = ({1'b0, cnt_q} == last);
        phase = (app_q.sh == '0) || ({1'b0, cnt_q} < half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            app_q <= '{rate: RATE_HIGH, sh: '0};
            cnt_q <= '0;
        end else if (tick) begin
            // boundary: the next period takes the current pick
            app_q <= pick;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign rate = app_q.rate;
    assign sh   = app_q.sh;

endmodule

// File: rtl/sysclk_rate_divider.sv
module sysclk_rate_divider
    import sysclk_div_pkg::*;
#(
    parameter int MAX_SHIFT = 8
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_hi_code,
    input  logic [2:0] cfg_lo_code,
    input  logic       cfg_sel_low,
    input  logic       cfg_wake_en,
    input  logic       ctl_busy,
    output logic       gclk_tick,
    output logic       gclk_phase,
    output logic       rate_is_low
);

    cfg_t   cfg_q;
    pick_t  pick;
    rate_e  app_rate;
    shift_t app_sh;

    sdiv_cfg_regs u_cfg (
        .clk     (clk_ref),
        .rst     (rst),
        .wr      (cfg_wr),
        .hi_code (cfg_hi_code),
        .lo_code (cfg_lo_code),
        .sel_low (cfg_sel_low),
        .wake_en (cfg_wake_en),
        .cfg     (cfg_q)
    );

    sdiv_rate_sel u_sel (
        .cfg  (cfg_q),
        .busy (ctl_busy),
        .pick (pick)
    );

    sdiv_period_gen #(
        .MAX_SHIFT (MAX_SHIFT)
    ) u_gen (
        .clk   (clk_ref),
        .rst   (rst),
        .pick  (pick),
        .tick  (gclk_tick),
        .phase (gclk_phase),
        .rate  (app_rate),
        .sh    (app_sh)
    );

    assign rate_is_low = (app_rate == RATE_LOW);

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker
    import sysclk_div_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   wr,
    input code_t  hi_code,
    input code_t  lo_code,
    input logic   busy,
    input logic   tick,
    input logic   phase,
    input logic   rate_low,
    input shift_t hi_sh,
    input shift_t lo_sh,
    input logic   sel_low,
    input logic   wake_en,
    input shift_t app_sh
);

    logic after_rst;
    logic armed;

    always_ff @(posedge clk) begin
        after_rst <= rst;
        armed     <= !rst;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        (after_rst && !rst) |-> (tick && phase && !rate_low));

    p_hi_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && hi_code == HI_RESERVED) |=> $stable(hi_sh));

    p_lo_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && lo_code == LO_RESERVED) |=> $stable(lo_sh));

    p_mid_period_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tick)) |-> $stable(app_sh));

    p_status_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tick)) |-> $stable(rate_low));

    p_busy_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tick) && $past(sel_low) && !$past(wake_en)) |-> rate_low);

    p_busy_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tick) && $past(sel_low && wake_en && busy)) |-> !rate_low);

    p_div_one_r9: assert property (@(posedge clk) disable iff (rst)
        (app_sh == '0) |-> (tick && phase));

    p_tick_in_low_half_r10: assert property (@(posedge clk) disable iff (rst)
        (app_sh != '0 && tick) |-> !phase);

endmodule

bind sysclk_rate_divider sdiv_checker u_chk (
    .clk      (clk_ref),
    .rst      (rst),
    .wr       (cfg_wr),
    .hi_code  (cfg_hi_code),
    .lo_code  (cfg_lo_code),
    .busy     (ctl_busy),
    .tick     (gclk_tick),
    .phase    (gclk_phase),
    .rate_low (rate_is_low),
    .hi_sh    (cfg_q.hi_sh),
    .lo_sh    (cfg_q.lo_sh),
    .sel_low  (cfg_q.sel_low),
    .wake_en  (cfg_q.wake_en),
    .app_sh   (app_sh)
);

// File: tb/tb_sysclk_rate_divider.sv
module tb_sysclk_rate_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_hi_code = 3'd0;
    logic [2:0] cfg_lo_code = 3'd0;
    logic       cfg_sel_low = 1'b0;
    logic       cfg_wake_en = 1'b0;
    logic       ctl_busy = 1'b0;
    logic       gclk_tick;
    logic       gclk_phase;
    logic       rate_is_low;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int m_hi = 0, m_lo = 1, m_app = 0, m_cnt = 0;
    bit m_sel = 0, m_wen = 0, m_low = 0;

    always #5 clk = ~clk;

    sysclk_rate_divider dut (
        .clk_ref     (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_hi_code (cfg_hi_code),
        .cfg_lo_code (cfg_lo_code),
        .cfg_sel_low (cfg_sel_low),
        .cfg_wake_en (cfg_wake_en),
        .ctl_busy    (ctl_busy),
        .gclk_tick   (gclk_tick),
        .gclk_phase  (gclk_phase),
        .rate_is_low (rate_is_low)
    );

    task automatic check(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // requirement tables R2 / R3, returning log2 of divisor (-1 = reserved)
    function automatic int hi_log(int c);
        return (c == 7) ? -1 : c;
    endfunction

    function automatic int lo_log(int c);
        if (c == 6) return -1;
        if (c == 7) return 8;
        return c + 1;
    endfunction

    task automatic model_edge();
        bit boundary;
        bit go_low;
        if (rst) begin
            m_hi = 0; m_lo = 1; m_sel = 0; m_wen = 0;
            m_app = 0; m_low = 0; m_cnt = 0;
        end else begin
            boundary = (m_cnt == (1 << m_app) - 1);
            if (boundary) begin
                go_low = m_sel && !(m_wen && ctl_busy);
                m_app  = go_low ? m_lo : m_hi;
                m_low  = go_low;
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
            if (cfg_wr) begin
                if (hi_log(cfg_hi_code) >= 0) m_hi = hi_log(cfg_hi_code);
                if (lo_log(cfg_lo_code) >= 0) m_lo = lo_log(cfg_lo_code);
                m_sel = cfg_sel_low;
                m_wen = cfg_wake_en;
            end
        end
    endtask

    // one reference cycle: model update at the edge, compare 2 ns later
    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2;
        check("R9 tick", int'(gclk_tick), int'(m_cnt == (1 << m_app) - 1));
        check("R10 phase", int'(gclk_phase),
              int'(m_app == 0 || m_cnt < ((1 << m_app) / 2)));
        check("R11 rate status", int'(rate_is_low), int'(m_low));
    endtask

    task automatic write_cfg(int h, int l, bit s, bit w);
        cfg_hi_code = 3'(h);
        cfg_lo_code = 3'(l);
        cfg_sel_low = s;
        cfg_wake_en = w;
        cfg_wr = 1'b1;
        cyc();
        cfg_wr = 1'b0;
    endtask

    // cycles between two consecutive ticks, taken after skipping one period
    task automatic measure(output int n);
        int c;
        for (int k = 0; k < 3; k++) begin
            c = 0;
            do begin
                cyc();
                c++;
            end while (!gclk_tick && c < 1000);
        end
        n = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        int prev;
        void'($urandom(32'd20240611));

        // reset (R1)
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        #1;
        check("R1 reset tick", int'(gclk_tick), 1);
        check("R1 reset phase", int'(gclk_phase), 1);
        check("R1 reset status", int'(rate_is_low), 0);
        cyc();
        check("R1 divide by one after reset", int'(gclk_tick), 1);

        // fast table (R2)
        for (int c = 0; c < 7; c++) begin
            write_cfg(c, 0, 1'b0, 1'b0);
            measure(n);
            check("R2 fast period", n, 1 << c);
        end

        // slow table (R3) and slow selection (R4)
        for (int c = 0; c < 8; c++) begin
            if (c == 6) continue;
            write_cfg(0, c, 1'b1, 1'b0);
            measure(n);
            check("R3 slow period", n, 1 << lo_log(c));
            check("R4 slow selected", int'(rate_is_low), 1);
        end

        // back to fast with sel_low=0 (R4)
        write_cfg(2, 2, 1'b0, 1'b0);
        measure(n);
        check("R4 fast selected", n, 4);
        check("R4 fast status", int'(rate_is_low), 0);

        // reserved codes (R8): fast field stays 4, slow field stays 8
        write_cfg(2, 2, 1'b0, 1'b0);
        write_cfg(7, 6, 1'b0, 1'b0);
        measure(n);
        check("R8 fast reserved keeps value", n, 4);
        write_cfg(7, 6, 1'b1, 1'b0);
        measure(n);
        check("R8 slow reserved keeps value", n, 8);
        check("R8 sel still written", int'(rate_is_low), 1);

        // busy with wake disabled (R6)
        write_cfg(0, 0, 1'b1, 1'b0);
        ctl_busy = 1'b1;
        measure(n);
        check("R6 busy ignored period", n, 2);
        check("R6 busy ignored status", int'(rate_is_low), 1);

        // busy with wake enabled (R5)
        write_cfg(0, 0, 1'b1, 1'b1);
        measure(n);
        check("R5 busy fast period", n, 1);
        check("R5 busy fast status", int'(rate_is_low), 0);
        ctl_busy = 1'b0;
        measure(n);
        check("R5 idle slow period", n, 2);
        check("R5 idle slow status", int'(rate_is_low), 1);

        // mid-period change (R7): divide by 64, rewrite to 1 at cycle 10
        write_cfg(6, 0, 1'b0, 1'b0);
        measure(n);
        check("R7 setup period", n, 64);
        repeat (9) cyc();
        write_cfg(0, 0, 1'b0, 1'b0);
        prev = 10;
        n = 0;
        while (!gclk_tick && n < 200) begin
            cyc();
            n++;
        end
        check("R7 old period completes", prev + n, 64);
        cyc();
        check("R7 new rate after boundary", int'(gclk_tick), 1);

        // random mix, boundaries colliding with writes and busy
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 5999) == 0) rst = 1'b1;
            else rst = 1'b0;
            if ($urandom_range(0, 7) == 0) ctl_busy = ~ctl_busy;
            if ($urandom_range(0, 29) == 0) begin
                cfg_wr      = 1'b1;
                cfg_hi_code = 3'($urandom_range(0, 7));
                cfg_lo_code = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                                          : 3'($urandom_range(0, 2));
                cfg_sel_low = 1'($urandom_range(0, 1));
                cfg_wake_en = 1'($urandom_range(0, 1));
            end else begin
                cfg_wr = 1'b0;
            end
            cyc();
        end
        rst = 1'b0;
        cfg_wr = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule